// File: doc/BRIEF.md
# Coprocessor Conditional Loop-Branch Sequencer

This block carries out a decrement-and-branch instruction whose condition comes from an external coprocessor. When `start` is pulsed, the block captures four values: the operation word, the condition-selector word, the signed 16-bit displacement and the scan program counter. The scan program counter is the address of the displacement word. The block first hands the selector to the coprocessor by writing it to the coprocessor's condition register. It then reads the coprocessor's response register, once per cycle, until it gets a definite answer. A service request is modelled as one extra cycle that the block spends before it reads the response again.

If the answer is true, the block does nothing to the register file and reports the address that follows the displacement word. If the answer is false, the block reads the data register chosen by the low three bits of the operation word. It subtracts one from the low 16 bits and writes the register back in a single cycle, leaving the upper 16 bits unchanged. It then branches to the scan program counter plus the sign-extended displacement. The exception is a counter that has wrapped to 16'hFFFF: in that case the block falls through instead of branching. The outcome is given as a one-cycle `done` pulse that carries `next_pc` and a `taken` flag.

Top module: `cp_loop_branch`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in its idle state. While idle, every output is zero.
- R2: In the cycle after `start` is sampled in idle, `cond_wr_en` is high for exactly one cycle and `cond_wr_data` holds the captured selector word. No response read happens before that write.
- R3: Response code 2'b00 means busy. The response register is read again in the very next cycle.
- R4: Response code 2'b01 means a service request. It costs one cycle with no response read, and the register is read again after that cycle.
- R5: Response code 2'b11 means true. It is followed by `done` with `taken`=0 and `next_pc` = scan PC + 2, and the register file is never written.
- R6: Response code 2'b10 means false. It is followed by exactly one `rf_wr_en` cycle that writes back the register selected by operation-word bits [2:0]. The written value keeps the upper 16 bits and has the low 16 bits decremented modulo 2^16. `rf_rd_idx` selects the same register.
- R7: On the false path, if the decremented low word equals 16'hFFFF, `done` follows with `taken`=0 and `next_pc` = scan PC + 2.
- R8: On the false path, if the decremented low word is anything other than 16'hFFFF, `done` follows with `taken`=1 and `next_pc` = scan PC + the sign-extended displacement.
- R9: `done` lasts one cycle. The instruction takes 1 + reads + service cycles + (1 if false) cycles from start to `done`.
- R10: While an instruction is in progress, `start` and all instruction inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (sampled when idle) |
| op_word | input | 16 | Operation word; bits [2:0] select the counter register |
| cond_sel | input | 16 | Condition-selector word |
| disp | input | 16 | Signed branch displacement |
| scan_pc | input | 32 | Address of the displacement word |
| busy | output | 1 | Instruction in progress |
| cond_wr_en | output | 1 | Write strobe to the coprocessor condition register |
| cond_wr_data | output | 16 | Selector being written |
| resp_rd_en | output | 1 | Read strobe of the coprocessor response register |
| resp_data | input | 2 | Response code read in the same cycle |
| rf_rd_idx | output | 3 | Register-file read index |
| rf_rd_data | input | 32 | Register-file read data |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_idx | output | 3 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |
| done | output | 1 | One-cycle completion pulse |
| next_pc | output | 32 | Next instruction address, valid with done |
| taken | output | 1 | Branch taken, valid with done |

## Verification
The bench goes after the counter boundaries: a low word of zero, a low word of one, and a low word of 16'hFFFF. A design that compared before decrementing, or tested the wrong value against minus one, would branch where it should fall through, or the other way round. Long runs of busy and service responses expose a design that skips a re-read or inserts no service cycle, because its start-to-done latency would come out wrong. A true answer checks that the register file is left alone. A negative displacement with a non-zero upper half checks sign extension and the preservation of the upper 16 bits. A second start pulse in the middle of an instruction, together with changed inputs, would corrupt the captured fields in a design that did not ignore it.

// File: rtl/cpdb_pkg.sv
package cpdb_pkg;

    localparam int SEQ_ADDR_W  = 32;
    localparam int SEQ_DATA_W  = 32;
    localparam int SEQ_CNT_W   = 16;
    localparam int SEQ_WORD_W  = 16;
    localparam int SEQ_IDX_W   = 3;
    localparam int SEQ_RESP_W  = 2;
    localparam int SEQ_STEP_B  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE_COND,
        ST_READ_RESP,
        ST_SERVICE,
        ST_DECREMENT,
        ST_DONE
    } seq_state_e;

    typedef enum logic [SEQ_RESP_W-1:0] {
        RSP_BUSY    = 2'b00,
        RSP_SERVICE = 2'b01,
        RSP_FALSE   = 2'b10,
        RSP_TRUE    = 2'b11
    } resp_code_e;

    typedef struct packed {
        logic                  taken;
        logic [SEQ_ADDR_W-1:0] pc;
    } seq_result_t;

endpackage

// File: rtl/cpdb_counter.sv
module cpdb_counter #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [DATA_W-1:0] cur_val,
    output logic [DATA_W-1:0] new_val,
    output logic              expired
);
    localparam int HI_W = DATA_W - CNT_W;

    logic [CNT_W-1:0] low_dec;

    always_comb begin
        low_dec = cur_val[CNT_W-1:0] - CNT_W'(1);
        expired = (low_dec == {CNT_W{1'b1}});
    end

    generate
        if (HI_W > 0) begin : g_keep_hi
            assign new_val = {cur_val[DATA_W-1:CNT_W], low_dec};
        end else begin : g_no_hi
            assign new_val = low_dec;
        end
    endgenerate
endmodule

// File: rtl/cpdb_target.sv
module cpdb_target #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int STEP_B = 2
) (
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DISP_W-1:0] disp_in,
    output logic [ADDR_W-1:0] fall_pc,
    output logic [ADDR_W-1:0] branch_pc
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;

    assign disp_ext  = {{EXT_W{disp_in[DISP_W-1]}}, disp_in};
    assign fall_pc   = pc_in + ADDR_W'(STEP_B);
    assign branch_pc = pc_in + disp_ext;
endmodule

// File: rtl/cpdb_ctrl.sv
module cpdb_ctrl
    import cpdb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [SEQ_RESP_W-1:0] resp_data,
    output logic                  load,
    output logic                  cap_true,
    output logic                  cap_dec,
    output logic                  busy,
    output logic                  cond_wr_en,
    output logic                  resp_rd_en,
    output logic                  rf_wr_en,
    output logic                  done
);
    seq_state_e state_q, state_d;
    resp_code_e rsp;

    assign rsp = resp_code_e'(resp_data);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:       if (start) state_d = ST_WRITE_COND;
            ST_WRITE_COND: state_d = ST_READ_RESP;
            ST_READ_RESP: begin
                case (rsp)
                    RSP_BUSY:    state_d = ST_READ_RESP;
                    RSP_SERVICE: state_d = ST_SERVICE;
                    RSP_FALSE:   state_d = ST_DECREMENT;
                    default:     state_d = ST_DONE;
                endcase
            end
            ST_SERVICE:    state_d = ST_READ_RESP;
            ST_DECREMENT:  state_d = ST_DONE;
            ST_DONE:       state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    assign load       = (state_q == ST_IDLE) && start;
    assign busy       = (state_q != ST_IDLE);
    assign cond_wr_en = (state_q == ST_WRITE_COND);
    assign resp_rd_en = (state_q == ST_READ_RESP);
    assign rf_wr_en   = (state_q == ST_DECREMENT);
    assign done       = (state_q == ST_DONE);
    assign cap_true   = resp_rd_en && (rsp == RSP_TRUE);
    assign cap_dec    = rf_wr_en;

    p_cond_once_r2: assert property (@(posedge clk) disable iff (rst)
        cond_wr_en |=> (!cond_wr_en && resp_rd_en));

    p_busy_reread_r3: assert property (@(posedge clk) disable iff (rst)
        (resp_rd_en && resp_data == 2'b00) |=> resp_rd_en);

    p_service_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (resp_rd_en && resp_data == 2'b01) |=> (!resp_rd_en ##1 resp_rd_en));

    p_true_nowrite_r5: assert property (@(posedge clk) disable iff (rst)
        (resp_rd_en && resp_data == 2'b11) |=> (done && !rf_wr_en));

    p_false_write_r6: assert property (@(posedge clk) disable iff (rst)
        (resp_rd_en && resp_data == 2'b10) |=> (rf_wr_en ##1 (done && !rf_wr_en)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_ignore_start_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && start) |=> busy);
endmodule

// File: rtl/cp_loop_branch.sv
module cp_loop_branch
    import cpdb_pkg::*;
#(
    parameter int ADDR_W = SEQ_ADDR_W,
    parameter int DATA_W = SEQ_DATA_W,
    parameter int CNT_W  = SEQ_CNT_W,
    parameter int WORD_W = SEQ_WORD_W,
    parameter int IDX_W  = SEQ_IDX_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [WORD_W-1:0]     op_word,
    input  logic [WORD_W-1:0]     cond_sel,
    input  logic [WORD_W-1:0]     disp,
    input  logic [ADDR_W-1:0]     scan_pc,
    output logic                  busy,
    output logic                  cond_wr_en,
    output logic [WORD_W-1:0]     cond_wr_data,
    output logic                  resp_rd_en,
    input  logic [SEQ_RESP_W-1:0] resp_data,
    output logic [IDX_W-1:0]      rf_rd_idx,
    input  logic [DATA_W-1:0]     rf_rd_data,
    output logic                  rf_wr_en,
    output logic [IDX_W-1:0]      rf_wr_idx,
    output logic [DATA_W-1:0]     rf_wr_data,
    output logic                  done,
    output logic [ADDR_W-1:0]     next_pc,
    output logic                  taken
);
    logic [WORD_W-1:0] op_q, sel_q, disp_q;
    logic [ADDR_W-1:0] pc_q;
    logic              res_taken_q;
    logic [ADDR_W-1:0] res_pc_q;

    logic              load, cap_true, cap_dec;
    logic [ADDR_W-1:0] fall_pc, branch_pc;
    logic [DATA_W-1:0] dec_val;
    logic              expired;
    logic [IDX_W-1:0]  reg_idx;

    cpdb_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .resp_data  (resp_data),
        .load       (load),
        .cap_true   (cap_true),
        .cap_dec    (cap_dec),
        .busy       (busy),
        .cond_wr_en (cond_wr_en),
        .resp_rd_en (resp_rd_en),
        .rf_wr_en   (rf_wr_en),
        .done       (done)
    );

    cpdb_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_counter (
        .cur_val (rf_rd_data),
        .new_val (dec_val),
        .expired (expired)
    );

    cpdb_target #(.ADDR_W(ADDR_W), .DISP_W(WORD_W), .STEP_B(SEQ_STEP_B)) u_target (
        .pc_in     (pc_q),
        .disp_in   (disp_q),
        .fall_pc   (fall_pc),
        .branch_pc (branch_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= '0;
            sel_q  <= '0;
            disp_q <= '0;
            pc_q   <= '0;
        end else if (load) begin
            op_q   <= op_word;
            sel_q  <= cond_sel;
            disp_q <= disp;
            pc_q   <= scan_pc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_taken_q <= 1'b0;
            res_pc_q    <= '0;
        end else if (cap_true) begin
            res_taken_q <= 1'b0;
            res_pc_q    <= fall_pc;
        end else if (cap_dec) begin
            res_taken_q <= !expired;
            res_pc_q    <= expired ? fall_pc : branch_pc;
        end
    end

    assign reg_idx      = op_q[IDX_W-1:0];
    assign rf_rd_idx    = busy ? reg_idx : '0;
    assign rf_wr_idx    = rf_wr_en ? reg_idx : '0;
    assign rf_wr_data   = rf_wr_en ? dec_val : '0;
    assign cond_wr_data = cond_wr_en ? sel_q : '0;
    assign next_pc      = done ? res_pc_q : '0;
    assign taken        = done & res_taken_q;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!cond_wr_en && !resp_rd_en && !rf_wr_en && !done && next_pc == '0));

    p_wrap_falls_r7: assert property (@(posedge clk) disable iff (rst)
        (rf_wr_en && rf_wr_data[CNT_W-1:0] == {CNT_W{1'b1}}) |=> (done && !taken));

    p_loop_branches_r8: assert property (@(posedge clk) disable iff (rst)
        (rf_wr_en && rf_wr_data[CNT_W-1:0] != {CNT_W{1'b1}}) |=> (done && taken));

    p_same_reg_r6: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en |-> (rf_wr_idx == rf_rd_idx));
endmodule

// File: tb/cp_loop_branch_tb.sv
module cp_loop_branch_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] op_word = '0, cond_sel = '0, disp = '0;
    logic [31:0] scan_pc = '0;
    logic        busy, cond_wr_en, resp_rd_en, rf_wr_en, done, taken;
    logic [15:0] cond_wr_data;
    logic [1:0]  resp_data = 2'b00;
    logic [2:0]  rf_rd_idx, rf_wr_idx;
    logic [31:0] rf_rd_data, rf_wr_data, next_pc;

    logic [31:0] regs [8];
    int checks = 0;
    int failures = 0;

    typedef struct {
        logic [31:0] pc;
        logic        tk;
        int          writes;
        int          reads;
        int          cycles;
        logic [2:0]  idx;
        logic [31:0] reg_after;
        logic [15:0] sel;
    } exp_t;

    exp_t        exp_q[$];
    logic [1:0]  rsp_q[$];

    always #10 clk = ~clk;

    cp_loop_branch dut_i (
        .clk(clk), .rst(rst), .start(start), .op_word(op_word), .cond_sel(cond_sel),
        .disp(disp), .scan_pc(scan_pc), .busy(busy), .cond_wr_en(cond_wr_en),
        .cond_wr_data(cond_wr_data), .resp_rd_en(resp_rd_en), .resp_data(resp_data),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en),
        .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .done(done),
        .next_pc(next_pc), .taken(taken)
    );

    assign rf_rd_data = regs[rf_rd_idx];

    always @(posedge clk) if (rf_wr_en) regs[rf_wr_idx] <= rf_wr_data;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Monitor: coprocessor model and scoreboard comparison.
    int   n_reads = 0, n_writes = 0, n_cyc = 0;
    bit   got_cond = 0;
    logic [15:0] seen_sel = '0;
    logic [2:0]  seen_idx = '0;
    always @(negedge clk) begin
        if (!rst) begin
            if (cond_wr_en) begin
                got_cond = 1;
                seen_sel = cond_wr_data;
            end
            if (resp_rd_en) begin
                check(got_cond, "R2", "read before cond write", 32'(got_cond), 32'd1);
                n_reads++;
                resp_data = (rsp_q.size() > 0) ? rsp_q.pop_front() : 2'b11;
            end
            if (rf_wr_en) begin
                n_writes++;
                seen_idx = rf_wr_idx;
                check(rf_rd_idx == rf_wr_idx, "R6", "read idx", 32'(rf_rd_idx), 32'(rf_wr_idx));
            end
            if (busy && !done) n_cyc++;
            if (done) begin
                exp_t e;
                e = exp_q.pop_front();
                check(next_pc == e.pc, e.tk ? "R8" : (e.writes > 0 ? "R7" : "R5"),
                      "next_pc", next_pc, e.pc);
                check(taken == e.tk, e.tk ? "R8" : "R7_R5", "taken", 32'(taken), 32'(e.tk));
                check(n_writes == e.writes, "R6", "write count", n_writes, e.writes);
                check(n_reads == e.reads, "R3", "response reads", n_reads, e.reads);
                check(n_cyc == e.cycles, "R9", "latency (R4 service gap)", n_cyc, e.cycles);
                check(seen_sel == e.sel, "R2", "selector", 32'(seen_sel), 32'(e.sel));
                check(regs[e.idx] == e.reg_after, "R6", "register value", regs[e.idx], e.reg_after);
                if (e.writes > 0)
                    check(seen_idx == e.idx, "R6", "write idx", 32'(seen_idx), 32'(e.idx));
                n_reads = 0; n_writes = 0; n_cyc = 0; got_cond = 0; seen_sel = '0;
            end
        end
    end

    always @(posedge clk) begin
        if (done) begin
            @(negedge clk);
            check(!done, "R9", "done width", 32'(done), 32'd0);
        end
    end

    // Driver: pushes the expected result, then starts the instruction.
    task automatic run_instr(input logic [15:0] op, input logic [15:0] sel,
                             input logic [15:0] dsp, input logic [31:0] pc,
                             input logic [31:0] init, input logic [1:0] script[$],
                             input bit poke);
        exp_t e;
        logic [15:0] lo;
        int svc = 0;
        bit fls;
        regs[op[2:0]] = init;
        fls = (script[script.size()-1] == 2'b10);
        foreach (script[k]) begin
            rsp_q.push_back(script[k]);
            if (script[k] == 2'b01) svc++;
        end
        e.idx = op[2:0]; e.sel = sel; e.reads = script.size();
        e.cycles = 1 + script.size() + svc + (fls ? 1 : 0);
        if (fls) begin
            lo = init[15:0] - 16'd1;
            e.writes = 1;
            e.reg_after = {init[31:16], lo};
            e.tk = (lo != 16'hFFFF);
            e.pc = e.tk ? pc + {{16{dsp[15]}}, dsp} : pc + 32'd2;
        end else begin
            e.writes = 0; e.reg_after = init; e.tk = 1'b0; e.pc = pc + 32'd2;
        end
        exp_q.push_back(e);
        @(negedge clk);
        op_word = op; cond_sel = sel; disp = dsp; scan_pc = pc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            // R10: a new start and changed inputs mid-instruction are ignored
            op_word = 16'hFFFF; cond_sel = 16'h5A5A; disp = 16'h0100; scan_pc = 32'hDEAD0000;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 100000) begin
                checks++; failures++;
                $display("FAIL watchdog actual=%0d expected=<100000", wd);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) regs[i] = 32'h0;
        repeat (3) @(negedge clk);
        check(!busy && !cond_wr_en && !resp_rd_en && !rf_wr_en && !done && next_pc == 0 && !taken,
              "R1", "outputs in reset", {busy, cond_wr_en, resp_rd_en, rf_wr_en, done, taken}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && rf_wr_idx == 0 && cond_wr_data == 0, "R1", "idle after reset",
              32'(busy), 32'd0);
        // R5: immediate true
        run_instr(16'hF243, 16'h000E, 16'h0020, 32'h0000_1000, 32'hABCD_0005, '{2'b11}, 0);
        // R8: false, low 5 -> 4, forward branch
        run_instr(16'hF245, 16'h0001, 16'h0010, 32'h0000_1000, 32'h1234_0005, '{2'b10}, 0);
        // R7: false, low 0 -> FFFF, fall through
        run_instr(16'hF242, 16'h0002, 16'h0040, 32'h0000_3000, 32'h7777_0000, '{2'b10}, 0);
        // R3 R4 R10: busy x3, service, false, low 1 -> 0, backward branch
        run_instr(16'hF241, 16'h0013, 16'hFFF0, 32'h0000_2000, 32'h8001_0001,
                  '{2'b00, 2'b00, 2'b00, 2'b01, 2'b10}, 1);
        // R4 R5: service, busy, true on register 7
        run_instr(16'hF247, 16'h0007, 16'h0008, 32'h0000_4000, 32'h0000_0000,
                  '{2'b01, 2'b00, 2'b11}, 0);
        // R8: low FFFF -> FFFE still branches, register 0
        run_instr(16'hF240, 16'h0009, 16'h8000, 32'h0001_0000, 32'hFFFF_FFFF,
                  '{2'b01, 2'b01, 2'b10}, 0);
        @(negedge clk);
        check(!busy && !done && next_pc == 0, "R1", "idle after run", 32'(busy), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule